// File: doc/BRIEF.md
# DMA Channel Interrupt Status Controller

This block gathers interrupt events from the channel engines of a multi-channel DMA engine. It sorts them into five event classes: transfer complete, block complete, source transaction, destination transaction and error. Each class keeps a sticky raw event bit for every channel and a per-channel enable mask. It offers a masked status view and a write-only acknowledge register. A summary register shows which classes have unmasked status pending. The block drives one registered interrupt line, which is gated by a global enable.

Software reaches all registers through a simple single-cycle read/write port. Reads are combinational from the address. Writes take effect at the clock edge on which the write strobe is high. The mask registers and the channel-enable register use a masked-write format. The upper byte of the write data selects which channels take the new value from the lower byte, so one channel can be changed without a read-modify-write sequence. The channel-enable register drives the `ch_en` output to the channel engines.

Top module: `dmairq_top`

## Requirements
- R1: After reset, every raw, mask and channel-enable bit and the global enable are 0, every register reads 0, and `irq` is 0.
- R2: An event input bit that is high at a clock edge sets the matching raw bit after that edge. The bit stays set until it is acknowledged.
- R3: Writing the acknowledge register of a class (address 4*class+3) clears each raw bit whose write-data bit in [7:0] is 1. Bits written 0 are left unchanged. The acknowledge register reads as 0.
- R4: If an event and an acknowledge for the same raw bit arrive in the same cycle, the raw bit stays set.
- R5: For every class, the status register (address 4*class+1) reads as raw (address 4*class) bitwise-ANDed with mask (address 4*class+2). The class order is 0 transfer, 1 block, 2 source transaction, 3 destination transaction, 4 error.
- R6: A write to a mask register updates channel bit i to write-data bit i only where write-data bit 8+i is 1. All other mask bits keep their value.
- R7: The channel-enable register (address 22) uses the same masked-write rule as R6, reads back its value, and drives the `ch_en` output.
- R8: The summary register (address 20) and the `class_pending` output have bit k set exactly when class k has a nonzero status.
- R9: `irq` is high in the cycle after an edge at which the global enable (bit 0 of address 21) was 1 and some class had nonzero status. Otherwise `irq` is low.
- R10: Clearing the global enable drops `irq` but leaves every raw bit unchanged.
- R11: Writes to read-only addresses (raw, status, summary) are ignored, and reads of unused addresses 23 to 31 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data; [15:8] are per-channel write enables for masked registers |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| evt_xfer | input | NUM_CH | Transfer-complete event pulses |
| evt_blk | input | NUM_CH | Block-complete event pulses |
| evt_srct | input | NUM_CH | Source-transaction event pulses |
| evt_dstt | input | NUM_CH | Destination-transaction event pulses |
| evt_err | input | NUM_CH | Error event pulses |
| ch_en | output | NUM_CH | Channel enable bits to the channel engines |
| class_pending | output | 5 | Per-class nonzero-status flags |
| irq | output | 1 | Registered interrupt request |

## Verification
The bound checker watches several rules on every cycle for each class and channel. An event sets its raw bit, and that includes an event that collides with an acknowledge. An acknowledge without an event clears the bit. A mask or the channel-enable value changes only on a write to its own address, and `irq` never rises unless the global enable was set the cycle before. The directed scenarios are needed for the rest. They cover the values read back through the register port, the partial effect of a masked write, the status and summary values for all five classes under one event pattern, the exact one-cycle latency of `irq`, and the fact that raw state survives when the global enable is switched off.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int NUM_CLS = 5;
  localparam int ADDR_W  = 5;
  localparam int REG_W   = 16;
  localparam int HALF_W  = REG_W / 2;
  localparam int MAX_CH  = HALF_W;
  localparam int CLS_W   = 3;

  localparam logic [ADDR_W-1:0] A_CLS_END = ADDR_W'(NUM_CLS * 4);
  localparam logic [ADDR_W-1:0] A_SUMMARY = ADDR_W'(NUM_CLS * 4);
  localparam logic [ADDR_W-1:0] A_CFG     = ADDR_W'(NUM_CLS * 4 + 1);
  localparam logic [ADDR_W-1:0] A_CHEN    = ADDR_W'(NUM_CLS * 4 + 2);

  typedef enum logic [1:0] {
    SUB_RAW  = 2'd0,
    SUB_STAT = 2'd1,
    SUB_MASK = 2'd2,
    SUB_ACK  = 2'd3
  } sub_e;
endpackage

// File: rtl/dmairq_rst_sync.sv
module dmairq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/dmairq_class_bank.sv
module dmairq_class_bank
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt,
  input  logic              ack_we,
  input  logic              mask_we,
  input  logic [REG_W-1:0]  wdata,
  output logic [NUM_CH-1:0] raw,
  output logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] status
);
  logic [NUM_CH-1:0] raw_q, raw_d;
  logic [NUM_CH-1:0] mask_q, mask_d;
  logic              raw_en, mask_en;

  // acknowledge first, event last: a colliding event keeps the bit set
  always_comb begin
    raw_d  = raw_q;
    mask_d = mask_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ack_we && wdata[i]) raw_d[i] = 1'b0;
      if (evt[i])             raw_d[i] = 1'b1;
      if (mask_we && wdata[HALF_W+i]) mask_d[i] = wdata[i];
    end
  end

  assign raw_en  = ack_we | (|evt);
  assign mask_en = mask_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (raw_en) begin
      raw_q <= raw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign raw    = raw_q;
  assign mask   = mask_q;
  assign status = raw_q & mask_q;
endmodule

// File: rtl/dmairq_chen.sv
module dmairq_chen
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [NUM_CH-1:0] en
);
  logic [NUM_CH-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (wdata[HALF_W+i]) en_d[i] = wdata[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (we) begin
      en_q <= en_d;
    end
  end

  assign en = en_q;
endmodule

// File: rtl/dmairq_top.sv
module dmairq_top
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [4:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [NUM_CH-1:0] evt_xfer,
  input  logic [NUM_CH-1:0] evt_blk,
  input  logic [NUM_CH-1:0] evt_srct,
  input  logic [NUM_CH-1:0] evt_dstt,
  input  logic [NUM_CH-1:0] evt_err,
  output logic [NUM_CH-1:0] ch_en,
  output logic [4:0]        class_pending,
  output logic              irq
);
  logic                               rst_core_n;
  logic [NUM_CLS-1:0][NUM_CH-1:0]     evt_v, raw_v, mask_v, status_v;
  logic                               in_cls;
  logic [CLS_W-1:0]                   cls_idx;
  sub_e                               sub;
  logic                               gen_en_q, gen_en_d, cfg_we;
  logic                               irq_q, irq_d;

  dmairq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  assign evt_v[0] = evt_xfer;
  assign evt_v[1] = evt_blk;
  assign evt_v[2] = evt_srct;
  assign evt_v[3] = evt_dstt;
  assign evt_v[4] = evt_err;

  assign in_cls  = (reg_addr < A_CLS_END);
  assign cls_idx = reg_addr[4:2];
  assign sub     = sub_e'(reg_addr[1:0]);

  for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
    logic hit;
    assign hit = reg_wr && in_cls && (cls_idx == CLS_W'(k));

    dmairq_class_bank #(.NUM_CH(NUM_CH)) u_bank (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .evt     (evt_v[k]),
      .ack_we  (hit && (sub == SUB_ACK)),
      .mask_we (hit && (sub == SUB_MASK)),
      .wdata   (reg_wdata),
      .raw     (raw_v[k]),
      .mask    (mask_v[k]),
      .status  (status_v[k])
    );

    assign class_pending[k] = |status_v[k];
  end

  dmairq_chen #(.NUM_CH(NUM_CH)) u_chen (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (reg_wr && (reg_addr == A_CHEN)),
    .wdata (reg_wdata),
    .en    (ch_en)
  );

  // global enable
  assign cfg_we   = reg_wr && (reg_addr == A_CFG);
  assign gen_en_d = reg_wdata[0];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      gen_en_q <= 1'b0;
    end else if (cfg_we) begin
      gen_en_q <= gen_en_d;
    end
  end

  // registered interrupt line
  assign irq_d = gen_en_q && (|class_pending);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (in_cls) begin
      unique case (sub)
        SUB_RAW:  reg_rdata[NUM_CH-1:0] = raw_v[cls_idx];
        SUB_STAT: reg_rdata[NUM_CH-1:0] = status_v[cls_idx];
        SUB_MASK: reg_rdata[NUM_CH-1:0] = mask_v[cls_idx];
        default:  reg_rdata = '0;
      endcase
    end else if (reg_addr == A_SUMMARY) begin
      reg_rdata[NUM_CLS-1:0] = class_pending;
    end else if (reg_addr == A_CFG) begin
      reg_rdata[0] = gen_en_q;
    end else if (reg_addr == A_CHEN) begin
      reg_rdata[NUM_CH-1:0] = ch_en;
    end
  end
endmodule

// File: rtl/dmairq_chk.sv
module dmairq_chk
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic                           clk,
  input logic                           rst_core_n,
  input logic                           reg_wr,
  input logic [4:0]                     reg_addr,
  input logic [15:0]                    reg_wdata,
  input logic [NUM_CLS-1:0][NUM_CH-1:0] evt_v,
  input logic [NUM_CLS-1:0][NUM_CH-1:0] raw_v,
  input logic [NUM_CLS-1:0][NUM_CH-1:0] mask_v,
  input logic [NUM_CH-1:0]              ch_en,
  input logic                           gen_en_q,
  input logic                           irq
);
  for (genvar k = 0; k < NUM_CLS; k++) begin : g_k
    assert_mask_only_on_write_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
      !(reg_wr && reg_addr == 5'(k*4+2)) |=> $stable(mask_v[k]));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_i
      assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
        evt_v[k][i] |=> raw_v[k][i]);

      assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
        (reg_wr && reg_addr == 5'(k*4+3) && reg_wdata[i] && !evt_v[k][i]) |=> !raw_v[k][i]);

      assert_collision_keeps_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
        (reg_wr && reg_addr == 5'(k*4+3) && reg_wdata[i] && evt_v[k][i]) |=> raw_v[k][i]);
    end
  end

  assert_chen_only_on_write_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(reg_wr && reg_addr == A_CHEN) |=> $stable(ch_en));

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq |-> $past(gen_en_q));
endmodule

bind dmairq_top dmairq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .evt_v      (evt_v),
  .raw_v      (raw_v),
  .mask_v     (mask_v),
  .ch_en      (ch_en),
  .gen_en_q   (gen_en_q),
  .irq        (irq)
);

// File: tb/dmairq_top_tb.sv
module dmairq_top_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [4:0]   reg_addr = '0;
  logic [15:0]  reg_wdata = '0;
  logic [15:0]  reg_rdata;
  logic [N-1:0] evt_xfer = '0, evt_blk = '0, evt_srct = '0, evt_dstt = '0, evt_err = '0;
  logic [N-1:0] ch_en;
  logic [4:0]   class_pending;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dmairq_top #(.NUM_CH(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_xfer(evt_xfer), .evt_blk(evt_blk), .evt_srct(evt_srct),
    .evt_dstt(evt_dstt), .evt_err(evt_err),
    .ch_en(ch_en), .class_pending(class_pending), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = 5'(a);
    #1 v = int'(reg_rdata);
  endtask

  task automatic pulse(input int cls, input int bits);
    @(negedge clk);
    case (cls)
      0: evt_xfer = N'(bits);
      1: evt_blk  = N'(bits);
      2: evt_srct = N'(bits);
      3: evt_dstt = N'(bits);
      default: evt_err = N'(bits);
    endcase
    @(negedge clk);
    evt_xfer = '0; evt_blk = '0; evt_srct = '0; evt_dstt = '0; evt_err = '0;
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 32; a++) begin
      rd(a, v);
      chk($sformatf("R1 reset read addr %0d", a), v, 0);
    end
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset ch_en", int'(ch_en), 0);
  endtask

  task automatic t_event_mask_irq();
    int v;
    pulse(0, 'h08);
    rd(0, v);  chk("R2 raw transfer after event", v, 'h08);
    rd(1, v);  chk("R5 status with mask zero", v, 0);
    wr(2, 'h0808);
    wr(2, 'h01FF);
    rd(2, v);  chk("R6 masked write touches only enabled channels", v, 'h09);
    rd(1, v);  chk("R5 status = raw & mask", v, 'h08);
    rd(20, v); chk("R8 summary transfer class", v, 'h01);
    chk("R8 class_pending output", int'(class_pending), 'h01);
    chk("R9 irq low while global enable off", int'(irq), 0);
    wr(21, 1);
    chk("R9 irq not yet high in write cycle", int'(irq), 0);
    @(negedge clk);
    chk("R9 irq high one cycle later", int'(irq), 1);
    rd(0, v);  chk("R2 raw still held", v, 'h08);
  endtask

  task automatic t_ack_collision();
    int v;
    pulse(1, 'h06);
    @(negedge clk);
    evt_blk = 8'h04; reg_wr = 1'b1; reg_addr = 5'd7; reg_wdata = 16'h0006;
    @(negedge clk);
    evt_blk = '0; reg_wr = 1'b0;
    rd(4, v);  chk("R4 event wins over ack; R3 other bit cleared", v, 'h04);
    wr(7, 'h0000);
    rd(4, v);  chk("R3 zero ack bits leave raw", v, 'h04);
    rd(7, v);  chk("R3 ack register reads zero", v, 0);
    wr(7, 'h0004);
    rd(4, v);  chk("R3 ack clears raw", v, 0);
  endtask

  task automatic t_global_off();
    int v;
    wr(21, 0);
    @(negedge clk);
    chk("R10 irq drops with global enable off", int'(irq), 0);
    rd(0, v);  chk("R10 raw kept after disable", v, 'h08);
    rd(21, v); chk("R10 config reads back", v, 0);
  endtask

  task automatic t_all_classes();
    int v;
    for (int k = 0; k < 5; k++) begin
      pulse(k, 'hA5);
      wr(4*k+2, 'hFF3C);
    end
    for (int k = 0; k < 5; k++) begin
      int exp_raw;
      exp_raw = (k == 0) ? ('hA5 | 'h08) : 'hA5;
      rd(4*k, v);   chk($sformatf("R2 raw class %0d", k), v, exp_raw);
      rd(4*k+1, v); chk($sformatf("R5 status class %0d", k), v, exp_raw & 'h3C);
    end
    rd(20, v); chk("R8 summary all classes", v, 'h1F);
    wr(4*4+3, 'h00FF);
    rd(20, v); chk("R8 summary after error ack", v, 'h0F);
  endtask

  task automatic t_chen();
    int v;
    wr(22, 'hFF55);
    chk("R7 ch_en output full write", int'(ch_en), 'h55);
    wr(22, 'h0300);
    rd(22, v); chk("R7 masked ch_en write", v, 'h54);
    chk("R7 ch_en output after masked write", int'(ch_en), 'h54);
  endtask

  task automatic t_map();
    int v;
    wr(8, 'hFFFF);
    rd(8, v);  chk("R11 write to raw ignored", v, 'hA5);
    wr(20, 'hFFFF);
    rd(20, v); chk("R11 write to summary ignored", v, 'h0F);
    wr(25, 'hFFFF);
    rd(25, v); chk("R11 unused address reads zero", v, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_event_mask_irq();
    t_ack_collision();
    t_global_off();
    t_all_classes();
    t_chen();
    t_map();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule